// File: doc/BRIEF.md
# DMA Queue-Pair Control Register File

This block is the software-visible control plane of a multi-channel descriptor DMA engine. Every channel owns a 256-byte register window. The window holds the base addresses of the submission and completion rings, their depths, the submission tail and completion head pointers, enable and pause controls, and a reset request. It also holds a read-only view of the channel engine's state, and a 13-bit interrupt status register with a matching mask. One global mode register selects root-complex or endpoint operation.

Software reaches the block through a single 32-bit port that carries a byte address, byte enables, a write strobe and a read strobe. The block presents the decoded fields to each channel engine as plain outputs. It takes back a 4-bit state code and a vector of one-cycle interrupt events from each engine, and it drives one level-sensitive interrupt line per channel.

Top module: `qpair_regfile`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except each channel's interrupt mask, which reads 0x1FFF. All interrupt lines, reset pulses, enables and the mode output are low.
- R2: Channel c's window starts at byte address c×0x100. The word offsets are: 0x00/0x04 submission base low/high, 0x08 submission depth, 0x0C submission tail, 0x10/0x14 completion base low/high, 0x18 completion depth, 0x1C completion head. A write changes only the addressed channel, and the stored values appear on that channel's outputs.
- R3: The depth and pointer registers are PTR_W bits wide, and the bits above PTR_W read zero. A depth register holds the ring size minus one, so a 1024-entry ring is programmed as 1023.
- R4: In the control register at offset 0x20, bit 0 is queue enable and bit 4 is queue pause. Both are read/write and drive q_enable and q_pause. All other bits of that register read zero.
- R5: Writing 1 to bit 0 of offset 0x24 raises that channel's q_reset for exactly one cycle, starting the cycle after the write. While q_reset is high the bit reads 1, and afterwards it reads 0.
- R6: In the cycle after the reset pulse, that channel's submission tail and completion head are zero. This takes priority over a write to either pointer made during the pulse. Other channels are untouched.
- R7: Offset 0x30 returns the channel's 4-bit engine state input in bits 3:0. Writes to it have no effect.
- R8: A one-cycle event on bit i sets interrupt status bit i (offset 0x40, bits 12:0). Writing 1 clears a bit, and writing 0 leaves it unchanged. An event in the same cycle as a clear of that bit leaves the bit set.
- R9: Each channel's interrupt line is the OR of its status bits that are not masked (offset 0x44, bits 12:0). A mask of 0x1FFF silences the line, and a mask of 0 passes every source.
- R10: The mode register at byte address 0x217C holds one bit, which drives mode_rc (1 = root-complex, 0 = endpoint).
- R11: Reads of an unmapped offset inside a window, of a window at or beyond NUM_CH, or of any other unmapped address return zero. Writes there change nothing.
- R12: Byte enable bit b gates byte b (bits 8b+7:8b) of every write. This includes the write-one-to-clear status, where only enabled bytes can clear bits.
- R13: Read data is registered. It appears the cycle after reg_rd, reflects register contents before any write in that same cycle, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mode_rc | output | 1 | Global root-complex mode select |
| q_enable | output | NUM_CH | Per-channel queue enable |
| q_pause | output | NUM_CH | Per-channel queue pause |
| q_reset | output | NUM_CH | Per-channel one-cycle reset pulse |
| sq_base | output | NUM_CH*64 | Submission ring base, 64 bits per channel |
| cq_base | output | NUM_CH*64 | Completion ring base, 64 bits per channel |
| sq_depth | output | NUM_CH*PTR_W | Submission ring depth minus one |
| cq_depth | output | NUM_CH*PTR_W | Completion ring depth minus one |
| sq_tail | output | NUM_CH*PTR_W | Submission tail pointer |
| cq_head | output | NUM_CH*PTR_W | Completion head pointer |
| ch_state | input | NUM_CH*4 | Engine state code per channel |
| ch_event | input | NUM_CH*13 | One-cycle interrupt events per channel |
| ch_irq | output | NUM_CH | Per-channel interrupt line |

## Verification
The bench builds the block with NUM_CH = 3 and PTR_W = 12, and leaves ADDR_W at 14. With three channels the window at 0x300 lies past the last channel while still inside the channel address range, so out-of-range window reads and writes are exercised next to real ones. A 12-bit pointer width leaves bits 31:12 of the depth and pointer registers unimplemented, so random all-ones writes show that those bits read zero. Random writes to the reset control, mixed with pointer writes, place pointer updates inside the reset pulse cycle.

// File: rtl/qpr_pkg.sv
// Package: shared constants and helpers for the queue-pair register file.
// Assumes 32-bit data words and windows of 256 bytes per channel.
package qpr_pkg;
    localparam int WIN_LSB   = 8;   // log2 of the per-channel window stride
    localparam int STATE_W   = 4;   // engine state code width
    localparam int IRQ_W     = 13;  // interrupt sources per channel
    localparam int WOFF_W    = 6;   // word offset width inside a window

    // word offsets (byte offset / 4)
    localparam logic [WOFF_W-1:0] W_SQ_LO    = 6'h00;
    localparam logic [WOFF_W-1:0] W_SQ_HI    = 6'h01;
    localparam logic [WOFF_W-1:0] W_SQ_DEPTH = 6'h02;
    localparam logic [WOFF_W-1:0] W_SQ_TAIL  = 6'h03;
    localparam logic [WOFF_W-1:0] W_CQ_LO    = 6'h04;
    localparam logic [WOFF_W-1:0] W_CQ_HI    = 6'h05;
    localparam logic [WOFF_W-1:0] W_CQ_DEPTH = 6'h06;
    localparam logic [WOFF_W-1:0] W_CQ_HEAD  = 6'h07;
    localparam logic [WOFF_W-1:0] W_CTRL     = 6'h08;
    localparam logic [WOFF_W-1:0] W_QRESET   = 6'h09;
    localparam logic [WOFF_W-1:0] W_STATE    = 6'h0C;
    localparam logic [WOFF_W-1:0] W_ISTAT    = 6'h10;
    localparam logic [WOFF_W-1:0] W_IMASK    = 6'h11;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_PAUSE_BIT = 4;

    localparam logic [15:0] MODE_BYTE_ADDR = 16'h217C;

    // Combine an old word with new data under per-byte enables.
    function automatic logic [31:0] qpr_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

    // Expand byte enables into a bit mask.
    function automatic logic [31:0] qpr_bemask(input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = {8{be[b]}};
        end
        return r;
    endfunction
endpackage

// File: rtl/qpr_irq_unit.sv
// Module: per-channel interrupt status and mask with one level output.
// Assumes events are one-cycle pulses and that the clear vector already
// carries byte-enable gating. An event wins over a clear of the same bit.
module qpr_irq_unit #(
    parameter int IRQ_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wval,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);
    // Status: clear by write-one, then set by events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | evt;
    end

    // Mask: resets to all sources masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= mask_wval;
    end

    // Level output from unmasked pending sources.
    always_comb irq = |(status & ~mask);

    AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt))); // R8
    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq); // R9
endmodule

// File: rtl/qpr_chan_regs.sv
// Module: one channel's register window (ring bases, depths, pointers,
// controls, state view, interrupt registers) and its read mux.
// Assumes PTR_W <= 32 and that wr_en is already qualified by channel decode.
module qpr_chan_regs
    import qpr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WOFF_W-1:0] woff,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    input  logic [STATE_W-1:0] state_in,
    input  logic [IRQ_W-1:0]  evt,
    output logic [31:0]       rd_word,
    output logic [63:0]       sq_base,
    output logic [63:0]       cq_base,
    output logic [PTR_W-1:0]  sq_depth,
    output logic [PTR_W-1:0]  cq_depth,
    output logic [PTR_W-1:0]  sq_tail,
    output logic [PTR_W-1:0]  cq_head,
    output logic              q_en,
    output logic              q_pause,
    output logic              q_rst,
    output logic              irq
);
    logic [31:0]      merged;
    logic [IRQ_W-1:0] status;
    logic [IRQ_W-1:0] mask;
    logic [IRQ_W-1:0] clr_bits;
    logic             mask_we;
    logic             rst_hit;

    // Read mux over the word offset; unmapped offsets return zero.
    always_comb begin
        rd_word = '0;
        case (woff)
            W_SQ_LO:    rd_word = sq_base[31:0];
            W_SQ_HI:    rd_word = sq_base[63:32];
            W_SQ_DEPTH: rd_word = 32'(sq_depth);
            W_SQ_TAIL:  rd_word = 32'(sq_tail);
            W_CQ_LO:    rd_word = cq_base[31:0];
            W_CQ_HI:    rd_word = cq_base[63:32];
            W_CQ_DEPTH: rd_word = 32'(cq_depth);
            W_CQ_HEAD:  rd_word = 32'(cq_head);
            W_CTRL: begin
                rd_word[CTRL_EN_BIT]    = q_en;
                rd_word[CTRL_PAUSE_BIT] = q_pause;
            end
            W_QRESET:   rd_word[0] = q_rst;
            W_STATE:    rd_word = 32'(state_in);
            W_ISTAT:    rd_word = 32'(status);
            W_IMASK:    rd_word = 32'(mask);
            default:    rd_word = '0;
        endcase
    end

    // Byte-merged write value of the addressed word.
    always_comb merged = qpr_merge(rd_word, wdata, be);

    // Reset request decode: bit 0 of the reset word, byte 0 enabled.
    always_comb rst_hit = wr_en && (woff == W_QRESET) && be[0] && wdata[0];

    // Interrupt register strobes with byte gating.
    always_comb begin
        clr_bits = (wr_en && woff == W_ISTAT) ? (wdata[IRQ_W-1:0] & qpr_bemask(be)[IRQ_W-1:0]) : '0;
        mask_we  = wr_en && (woff == W_IMASK);
    end

    // Self-clearing reset pulse, high for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) q_rst <= 1'b0;
        else        q_rst <= rst_hit;
    end

    // Writable registers; the reset pulse overrides pointer writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_base  <= '0;
            cq_base  <= '0;
            sq_depth <= '0;
            cq_depth <= '0;
            sq_tail  <= '0;
            cq_head  <= '0;
            q_en     <= 1'b0;
            q_pause  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (woff)
                    W_SQ_LO:    sq_base[31:0]  <= merged;
                    W_SQ_HI:    sq_base[63:32] <= merged;
                    W_SQ_DEPTH: sq_depth       <= merged[PTR_W-1:0];
                    W_SQ_TAIL:  sq_tail        <= merged[PTR_W-1:0];
                    W_CQ_LO:    cq_base[31:0]  <= merged;
                    W_CQ_HI:    cq_base[63:32] <= merged;
                    W_CQ_DEPTH: cq_depth       <= merged[PTR_W-1:0];
                    W_CQ_HEAD:  cq_head        <= merged[PTR_W-1:0];
                    W_CTRL: begin
                        q_en    <= merged[CTRL_EN_BIT];
                        q_pause <= merged[CTRL_PAUSE_BIT];
                    end
                    default: ;
                endcase
            end
            if (q_rst) begin
                sq_tail <= '0;
                cq_head <= '0;
            end
        end
    end

    qpr_irq_unit #(.IRQ_W(IRQ_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .clr_bits  (clr_bits),
        .mask_we   (mask_we),
        .mask_wval (merged[IRQ_W-1:0]),
        .status    (status),
        .mask      (mask),
        .irq       (irq)
    );

    AST_RST_CLEARS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        q_rst |=> (sq_tail == '0 && cq_head == '0)); // R6
endmodule

// File: rtl/qpair_regfile.sv
// Module: top of the queue-pair register file. Decodes the byte address
// into a channel window or the global mode word, fans writes out to the
// channel instances and registers the read data.
// Assumes ADDR_W covers both NUM_CH windows and the mode word.
module qpair_regfile
    import qpr_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [3:0]                reg_be,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      mode_rc,
    output logic [NUM_CH-1:0]         q_enable,
    output logic [NUM_CH-1:0]         q_pause,
    output logic [NUM_CH-1:0]         q_reset,
    output logic [NUM_CH*64-1:0]      sq_base,
    output logic [NUM_CH*64-1:0]      cq_base,
    output logic [NUM_CH*PTR_W-1:0]   sq_depth,
    output logic [NUM_CH*PTR_W-1:0]   cq_depth,
    output logic [NUM_CH*PTR_W-1:0]   sq_tail,
    output logic [NUM_CH*PTR_W-1:0]   cq_head,
    input  logic [NUM_CH*STATE_W-1:0] ch_state,
    input  logic [NUM_CH*IRQ_W-1:0]   ch_event,
    output logic [NUM_CH-1:0]         ch_irq
);
    localparam int CH_W = ADDR_W - WIN_LSB;
    localparam logic [ADDR_W-3:0] MODE_WADDR = MODE_BYTE_ADDR[ADDR_W-1:2];

    logic [CH_W-1:0]   ch_idx;
    logic [WOFF_W-1:0] woff;
    logic [NUM_CH-1:0] ch_hit;
    logic [31:0]       ch_rd [NUM_CH];
    logic              mode_hit;
    logic              unmapped;
    logic [31:0]       rd_mux;

    // Address split into window index and word offset.
    always_comb begin
        ch_idx   = reg_addr[ADDR_W-1:WIN_LSB];
        woff     = reg_addr[WIN_LSB-1:2];
        mode_hit = (reg_addr[ADDR_W-1:2] == MODE_WADDR);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Window select for this channel.
        always_comb ch_hit[c] = (ch_idx == CH_W'(c));

        qpr_chan_regs #(.PTR_W(PTR_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && ch_hit[c]),
            .woff     (woff),
            .wdata    (reg_wdata),
            .be       (reg_be),
            .state_in (ch_state[c*STATE_W +: STATE_W]),
            .evt      (ch_event[c*IRQ_W +: IRQ_W]),
            .rd_word  (ch_rd[c]),
            .sq_base  (sq_base[c*64 +: 64]),
            .cq_base  (cq_base[c*64 +: 64]),
            .sq_depth (sq_depth[c*PTR_W +: PTR_W]),
            .cq_depth (cq_depth[c*PTR_W +: PTR_W]),
            .sq_tail  (sq_tail[c*PTR_W +: PTR_W]),
            .cq_head  (cq_head[c*PTR_W +: PTR_W]),
            .q_en     (q_enable[c]),
            .q_pause  (q_pause[c]),
            .q_rst    (q_reset[c]),
            .irq      (ch_irq[c])
        );
    end

    // Read data select: selected window, mode word, else zero.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) rd_mux = ch_rd[c];
        end
        if (mode_hit) rd_mux = {31'b0, mode_rc};
        unmapped = !(|ch_hit) && !mode_hit;
    end

    // Registered read port; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // Global mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mode_rc <= 1'b0;
        else if (reg_wr && mode_hit && reg_be[0]) mode_rc <= reg_wdata[0];
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && unmapped) |=> (reg_rdata == '0)); // R11
    AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && mode_hit && reg_be[0]) |=> (mode_rc == $past(reg_wdata[0]))); // R10
    AST_RESET_PULSE_ONEHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (q_reset == '0)); // R5
endmodule

// File: tb/qpair_regfile_tb.sv
`timescale 1ns/1ps
module qpair_regfile_tb;
    localparam int NCH = 3;
    localparam int PW  = 12;
    localparam int AW  = 14;
    localparam int IW  = 13;
    localparam logic [31:0] PMASK = (32'd1 << PW) - 1;

    // bench-side offsets
    localparam logic [7:0] O_SQLO = 8'h00, O_SQHI = 8'h04, O_SQD = 8'h08, O_SQT = 8'h0C;
    localparam logic [7:0] O_CQLO = 8'h10, O_CQHI = 8'h14, O_CQD = 8'h18, O_CQH = 8'h1C;
    localparam logic [7:0] O_CTL = 8'h20, O_RST = 8'h24, O_STA = 8'h30, O_IST = 8'h40, O_IMK = 8'h44;
    localparam logic [AW-1:0] A_MODE = 14'h217C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [3:0] reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mode_rc;
    logic [NCH-1:0] q_enable, q_pause, q_reset, ch_irq;
    logic [NCH*64-1:0] sq_base, cq_base;
    logic [NCH*PW-1:0] sq_depth, cq_depth, sq_tail, cq_head;
    logic [NCH*4-1:0] ch_state = '0;
    logic [NCH*IW-1:0] ch_event = '0;

    always #2 clk = ~clk;

    qpair_regfile #(.NUM_CH(NCH), .PTR_W(PW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode_rc(mode_rc), .q_enable(q_enable),
        .q_pause(q_pause), .q_reset(q_reset), .sq_base(sq_base), .cq_base(cq_base),
        .sq_depth(sq_depth), .cq_depth(cq_depth), .sq_tail(sq_tail), .cq_head(cq_head),
        .ch_state(ch_state), .ch_event(ch_event), .ch_irq(ch_irq)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model
    logic [31:0] m_sqlo[NCH], m_sqhi[NCH], m_cqlo[NCH], m_cqhi[NCH];
    logic [31:0] m_sqd[NCH], m_sqt[NCH], m_cqd[NCH], m_cqh[NCH];
    logic m_en[NCH], m_pa[NCH], m_pend[NCH];
    logic [IW-1:0] m_st[NCH], m_mk[NCH];
    logic m_mode;
    logic [31:0] m_rdata;

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] bem(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        int c;
        if (a[AW-1:2] == A_MODE[AW-1:2]) return {31'b0, m_mode};
        c = int'(a[AW-1:8]);
        if (c >= NCH) return 32'h0;
        case ({a[7:2], 2'b00})
            O_SQLO: return m_sqlo[c];
            O_SQHI: return m_sqhi[c];
            O_SQD:  return m_sqd[c];
            O_SQT:  return m_sqt[c];
            O_CQLO: return m_cqlo[c];
            O_CQHI: return m_cqhi[c];
            O_CQD:  return m_cqd[c];
            O_CQH:  return m_cqh[c];
            O_CTL:  return {27'b0, m_pa[c], 3'b0, m_en[c]};
            O_RST:  return {31'b0, m_pend[c]};
            O_STA:  return {28'b0, ch_state[c*4 +: 4]};
            O_IST:  return 32'(m_st[c]);
            O_IMK:  return 32'(m_mk[c]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_sqlo[c] = 0; m_sqhi[c] = 0; m_cqlo[c] = 0; m_cqhi[c] = 0;
            m_sqd[c] = 0; m_sqt[c] = 0; m_cqd[c] = 0; m_cqh[c] = 0;
            m_en[c] = 0; m_pa[c] = 0; m_pend[c] = 0; m_st[c] = 0; m_mk[c] = '1;
        end
        m_mode = 0; m_rdata = 0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: optional write and/or read, plus events; model follows
    task automatic op(input bit wr, input bit rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [3:0] be,
                      input logic [NCH*IW-1:0] ev, input string req);
        logic [31:0] e;
        logic nxt_pend[NCH];
        int c;
        e = exp_read(a);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; reg_be = be; ch_event = ev;
        @(posedge clk);
        #1;
        reg_wr = 0; reg_rd = 0; ch_event = '0;
        for (int k = 0; k < NCH; k++) nxt_pend[k] = 1'b0;
        c = int'(a[AW-1:8]);
        if (wr) begin
            if (a[AW-1:2] == A_MODE[AW-1:2]) begin
                if (be[0]) m_mode = d[0];
            end else if (c < NCH) begin
                case ({a[7:2], 2'b00})
                    O_SQLO: m_sqlo[c] = mrg(m_sqlo[c], d, be);
                    O_SQHI: m_sqhi[c] = mrg(m_sqhi[c], d, be);
                    O_SQD:  m_sqd[c]  = mrg(m_sqd[c], d, be) & PMASK;
                    O_SQT:  m_sqt[c]  = mrg(m_sqt[c], d, be) & PMASK;
                    O_CQLO: m_cqlo[c] = mrg(m_cqlo[c], d, be);
                    O_CQHI: m_cqhi[c] = mrg(m_cqhi[c], d, be);
                    O_CQD:  m_cqd[c]  = mrg(m_cqd[c], d, be) & PMASK;
                    O_CQH:  m_cqh[c]  = mrg(m_cqh[c], d, be) & PMASK;
                    O_CTL: if (be[0]) begin m_en[c] = d[0]; m_pa[c] = d[4]; end
                    O_RST:  nxt_pend[c] = be[0] & d[0];
                    O_IST:  m_st[c] = m_st[c] & ~(d[IW-1:0] & bem(be)[IW-1:0]);
                    O_IMK:  m_mk[c] = mrg(32'(m_mk[c]), d, be) & 32'h1FFF;
                    default: ;
                endcase
            end
        end
        for (int k = 0; k < NCH; k++) begin
            if (m_pend[k]) begin m_sqt[k] = 0; m_cqh[k] = 0; end
            m_pend[k] = nxt_pend[k];
            m_st[k] = m_st[k] | ev[k*IW +: IW];
        end
        if (rd) m_rdata = e;
        chk(reg_rdata, m_rdata, {req, " R13 rdata"});
        chk({31'b0, mode_rc}, {31'b0, m_mode}, {req, " R10 mode_rc"});
        for (int k = 0; k < NCH; k++) begin
            chk({31'b0, q_enable[k]}, {31'b0, m_en[k]}, {req, " R4 q_enable"});
            chk({31'b0, q_pause[k]}, {31'b0, m_pa[k]}, {req, " R4 q_pause"});
            chk({31'b0, q_reset[k]}, {31'b0, m_pend[k]}, {req, " R5 q_reset"});
            chk(32'(sq_tail[k*PW +: PW]), m_sqt[k], {req, " R6 sq_tail"});
            chk(32'(cq_head[k*PW +: PW]), m_cqh[k], {req, " R6 cq_head"});
            chk(sq_base[k*64 +: 32], m_sqlo[k], {req, " R2 sq_base"});
            chk(32'(cq_depth[k*PW +: PW]), m_cqd[k], {req, " R3 cq_depth"});
            chk({31'b0, ch_irq[k]}, {31'b0, |(m_st[k] & ~m_mk[k])}, {req, " R9 ch_irq"});
        end
    endtask

    function automatic logic [AW-1:0] ad(input int c, input logic [7:0] o);
        return AW'(c * 256) | AW'(o);
    endfunction

    initial begin
        logic [7:0] offs[16];
        logic [NCH*IW-1:0] ev;
        void'($urandom(32'd20240611));
        offs = '{O_SQLO, O_SQHI, O_SQD, O_SQT, O_CQLO, O_CQHI, O_CQD, O_CQH,
                 O_CTL, O_RST, O_STA, O_IST, O_IMK, 8'h28, 8'h3C, 8'hFC};
        model_reset();
        ch_state = 12'h5A3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values of every register
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 16; i++) op(0, 1, ad(c, offs[i]), 0, 0, '0, "R1 reset");

        // R5 R6: reset pulse clears pointers, overrides a write in the pulse
        op(1, 0, ad(1, O_SQT), 32'h5, 4'hF, '0, "R6 set tail");
        op(1, 0, ad(1, O_CQH), 32'h7, 4'hF, '0, "R6 set head");
        op(1, 0, ad(0, O_SQT), 32'h9, 4'hF, '0, "R6 other ch");
        op(1, 0, ad(1, O_RST), 32'h1, 4'h1, '0, "R5 request");
        op(1, 1, ad(1, O_SQT), 32'h33, 4'hF, '0, "R6 write during pulse");
        op(0, 1, ad(1, O_SQT), 0, 0, '0, "R6 tail cleared");
        op(0, 1, ad(0, O_SQT), 0, 0, '0, "R6 other untouched");
        op(0, 1, ad(1, O_RST), 0, 0, '0, "R5 reads zero after");
        op(1, 0, ad(1, O_RST), 32'h1, 4'h2, '0, "R12 reset byte gated");

        // R7: state view, writes ignored
        ch_state = 12'h9C4;
        op(1, 1, ad(2, O_STA), 32'hFFFF_FFFF, 4'hF, '0, "R7 write state");
        op(0, 1, ad(2, O_STA), 0, 0, '0, "R7 read state");

        // R8 R9: events, W1C, mask
        op(1, 0, ad(0, O_IMK), 32'h0, 4'hF, '0, "R9 unmask");
        ev = '0; ev[3] = 1'b1;
        op(0, 1, ad(0, O_IST), 0, 0, ev, "R8 event");
        op(0, 1, ad(0, O_IST), 0, 0, '0, "R8 status set");
        op(1, 0, ad(0, O_IST), 32'h0, 4'hF, '0, "R8 write zero");
        op(1, 0, ad(0, O_IST), 32'h8, 4'hE, '0, "R12 clear gated");
        op(1, 0, ad(0, O_IST), 32'h8, 4'h1, ev, "R8 event wins over clear");
        op(0, 1, ad(0, O_IST), 0, 0, '0, "R8 still set");
        op(1, 0, ad(0, O_IMK), 32'h1FFF, 4'hF, '0, "R9 mask all");
        op(1, 0, ad(0, O_IST), 32'h1FFF, 4'h3, '0, "R8 clear");

        // R3: depth of a 1024-entry ring, and upper bits
        op(1, 0, ad(2, O_SQD), 32'd1023, 4'hF, '0, "R3 depth 1023");
        op(0, 1, ad(2, O_SQD), 0, 0, '0, "R3 read 1023");
        op(1, 0, ad(2, O_CQD), 32'hFFFF_FFFF, 4'hF, '0, "R3 all ones");
        op(0, 1, ad(2, O_CQD), 0, 0, '0, "R3 truncated");

        // R10 R11 R12 directed
        op(1, 0, A_MODE, 32'h1, 4'h1, '0, "R10 set mode");
        op(0, 1, A_MODE, 0, 0, '0, "R10 read mode");
        op(1, 1, ad(NCH, O_SQLO), 32'hDEAD_BEEF, 4'hF, '0, "R11 window past end");
        op(0, 1, ad(0, 8'h28), 0, 0, '0, "R11 gap offset");
        op(0, 1, 14'h3FFC, 0, 0, '0, "R11 top address");
        op(1, 0, ad(1, O_CQHI), 32'hA1B2_C3D4, 4'h5, '0, "R12 byte write");
        op(0, 1, ad(1, O_CQHI), 0, 0, '0, "R12 byte read");
        op(1, 0, ad(0, O_CTL), 32'hFFFF_FFFF, 4'hF, '0, "R4 ctrl all ones");
        op(0, 1, ad(0, O_CTL), 0, 0, '0, "R4 ctrl read");
        op(0, 0, ad(0, O_CTL), 0, 0, '0, "R13 hold");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int c;
            logic [AW-1:0] a;
            c = int'($urandom % (NCH + 1));
            a = ad(c, offs[$urandom % 16]);
            if (($urandom % 16) == 0) a = A_MODE;
            ev = '0;
            if (($urandom % 6) == 0) ev = NCH*IW'({$urandom, $urandom} & {$urandom, $urandom});
            if (($urandom % 10) == 0) ch_state = 12'($urandom);
            op(1'($urandom), 1'($urandom), a, $urandom, 4'($urandom), ev, "R2 random");
        end
        op(0, 0, 0, 0, 0, '0, "R2 flush");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule